// File: doc/BRIEF.md
# Event Connectivity Mapper

This block turns each incoming address event into zero, one or several outgoing address events. An event arrives as a 16-bit neuron label on a four-phase request/acknowledge port. The label selects one word of a pointer table. The two top bits of that word, bits 23:22, say what to do with the event.

Type 00 drops the event. Type 11 sends one event whose target is the word's low 16 bits. Type 01 holds the address of a run of target words in a separate segment store. The block then walks that run in ascending address order and sends one event per word. The walk stops after a word tagged 10. A word tagged 00 or 01 inside a run is a corrupt run: the walk stops there and a sticky error flag is set.

The output side is also a four-phase request/acknowledge port. The input acknowledge is held back until every output event for the current input has been acknowledged. Both stores are loaded through one plain write port. `wr_seg` picks the store and `wr_addr` picks the word.

Top module: `evmap_top`

## Requirements
- R1: After reset, `out_req`, `in_ack` and `err_flag` are all low.
- R2: A table word of type 00 produces no output event, and `in_ack` rises on the second clock edge after `in_req` is first sampled high.
- R3: A table word of type 11 produces exactly one output event with `out_addr` equal to the word's bits 15:0. `out_req` rises on the second clock edge after `in_req` is first sampled high.
- R4: A table word of type 01 starts a walk at the segment address held in its low bits. Each segment word of type 11, and then the closing word of type 10, is emitted in ascending address order with `out_addr` equal to bits 15:0. The first `out_req` comes four edges after `in_req` is sampled. Each later `out_req` comes three edges after `out_ack` falls.
- R5: `in_ack` rises only after the last output event of the current input has been acknowledged. `in_ack` and `out_req` are never high together.
- R6: Four-phase timing holds on both ports:
  - `out_req` and `out_addr` hold until `out_ack` is high.
  - `out_req` then falls on the next edge.
  - `in_ack` stays high until `in_req` falls, and then falls on the next edge.
- R7: A segment word of type 00 or 01 met during a walk is not emitted. It ends the walk and sets `err_flag`, which stays high until reset.
- R8: A table word of type 10 is treated as a drop: no output event, and no change to `err_flag`.
- R9: A write with `wr_seg`=0 updates the table word at `wr_addr`, and a write with `wr_seg`=1 updates the segment word at `wr_addr`. Events that arrive after the write use the new contents.
- R10: Only the low TBL_AW bits of `in_label` select the table word (10 by default, 16 for a full 64K table). Higher label bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_req | input | 1 | Input event request |
| in_label | input | 16 | Label of the input event |
| in_ack | output | 1 | Input acknowledge, high once fan-out is done |
| out_req | output | 1 | Output event request |
| out_addr | output | 16 | Target address of the output event |
| out_ack | input | 1 | Output acknowledge |
| wr_en | input | 1 | Store write strobe |
| wr_seg | input | 1 | Store select: 0 table, 1 segment |
| wr_addr | input | 10 | Word address of the write |
| wr_data | input | 24 | Word written |
| err_flag | output | 1 | Sticky corrupt-segment flag |

## Verification
Every result has a fixed due cycle, counted from the falling edge at which the bench raises `in_req`:
- A drop acknowledges two edges later.
- A direct event requests two edges later.
- A walk requests its first event four edges later.
- Each following target requests three edges after the bench releases `out_ack`.
- The final acknowledge comes one edge after the last release.

The bench counts falling edges from each stimulus and compares each count with these figures. It compares every output address with a queue that it fills from its own mirror of both stores. At every falling edge it also checks that the two ports never request and acknowledge together.

// File: rtl/evmap_pkg.sv
package evmap_pkg;

   // Type field held in bits [WORD_W-1 -: 2] of table and segment words
   typedef enum logic [1:0] {
      KIND_NULL   = 2'b00,
      KIND_HEAD   = 2'b01,
      KIND_TAIL   = 2'b10,
      KIND_DIRECT = 2'b11
   } kind_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TDEC,
      ST_SRD,
      ST_SDEC,
      ST_OREQ,
      ST_OREL,
      ST_DONE
   } state_e;

endpackage

// File: rtl/evmap_ram.sv
module evmap_ram #(
   parameter int AW = 10,
   parameter int DW = 24
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/evmap_ctrl.sv
module evmap_ctrl
   import evmap_pkg::*;
#(
   parameter int WORD_W = 24,
   parameter int OUT_W  = 16,
   parameter int SEG_AW = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_req,
   output logic              in_ack,
   input  logic [WORD_W-1:0] tbl_word,
   input  logic [WORD_W-1:0] seg_word,
   output logic [SEG_AW-1:0] seg_raddr,
   output logic              out_req,
   output logic [OUT_W-1:0]  out_addr,
   input  logic              out_ack,
   output logic              err_flag
);
   localparam int KIND_LSB = WORD_W - 2;

   state_e            st;
   logic [SEG_AW-1:0] ptr;
   logic              last;
   kind_e             tkind, skind;

   assign tkind     = kind_e'(tbl_word[KIND_LSB +: 2]);
   assign skind     = kind_e'(seg_word[KIND_LSB +: 2]);
   assign seg_raddr = ptr;
   assign out_req   = (st == ST_OREQ);
   assign in_ack    = (st == ST_DONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         ptr      <= '0;
         last     <= 1'b0;
         out_addr <= '0;
         err_flag <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: if (in_req) st <= ST_TDEC;
            ST_TDEC: begin
               unique case (tkind)
                  KIND_DIRECT: begin
                     out_addr <= tbl_word[OUT_W-1:0];
                     last     <= 1'b1;
                     st       <= ST_OREQ;
                  end
                  KIND_HEAD: begin
                     ptr <= tbl_word[SEG_AW-1:0];
                     st  <= ST_SRD;
                  end
                  default: st <= ST_DONE;
               endcase
            end
            ST_SRD: st <= ST_SDEC;
            ST_SDEC: begin
               unique case (skind)
                  KIND_DIRECT, KIND_TAIL: begin
                     out_addr <= seg_word[OUT_W-1:0];
                     last     <= (skind == KIND_TAIL);
                     st       <= ST_OREQ;
                  end
                  default: begin
                     err_flag <= 1'b1;
                     st       <= ST_DONE;
                  end
               endcase
            end
            ST_OREQ: if (out_ack) st <= ST_OREL;
            ST_OREL: begin
               if (!out_ack) begin
                  if (last) st <= ST_DONE;
                  else begin
                     ptr <= ptr + 1'b1;
                     st  <= ST_SRD;
                  end
               end
            end
            ST_DONE: if (!in_req) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R5: never acknowledge the input while an output event is pending
   assert_ack_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_ack && out_req));

   // R6: output request and address hold until acknowledged
   assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_req && !out_ack) |=> (out_req && $stable(out_addr)));

   // R6: request released one edge after acknowledge seen
   assert_req_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_req && out_ack) |=> !out_req);

   // R6: input acknowledge holds while input request stays high
   assert_in_ack_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ack && in_req) |=> in_ack);

   // R7: error flag is sticky
   assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);

   // R5: no acknowledge without a request
   assert_ack_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ack) |-> in_req);
endmodule

// File: rtl/evmap_top.sv
module evmap_top
   import evmap_pkg::*;
#(
   parameter int LBL_W  = 16,
   parameter int TBL_AW = 10,
   parameter int SEG_AW = 10,
   parameter int WORD_W = 24,
   parameter int OUT_W  = 16,
   localparam int WA_W  = (TBL_AW > SEG_AW) ? TBL_AW : SEG_AW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_req,
   input  logic [LBL_W-1:0]  in_label,
   output logic              in_ack,
   output logic              out_req,
   output logic [OUT_W-1:0]  out_addr,
   input  logic              out_ack,
   input  logic              wr_en,
   input  logic              wr_seg,
   input  logic [WA_W-1:0]   wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   output logic              err_flag
);
   localparam int PAY_W = WORD_W - 2;

   // elaboration-time parameter checks
   if (TBL_AW > LBL_W)  begin : g_bad_tbl  $error("TBL_AW exceeds label width"); end
   if (OUT_W > PAY_W)   begin : g_bad_out  $error("OUT_W does not fit in word payload"); end
   if (SEG_AW > PAY_W)  begin : g_bad_seg  $error("SEG_AW does not fit in word payload"); end

   logic [TBL_AW-1:0] tbl_idx;
   logic [WORD_W-1:0] tbl_word, seg_word;
   logic [SEG_AW-1:0] seg_raddr;

   // R10: only the low TBL_AW label bits select the table word
   if (TBL_AW == LBL_W) begin : g_idx_full
      assign tbl_idx = in_label;
   end else begin : g_idx_part
      logic unused_hi;
      assign tbl_idx   = in_label[TBL_AW-1:0];
      assign unused_hi = ^in_label[LBL_W-1:TBL_AW];
   end

   if (PAY_W > OUT_W && PAY_W > SEG_AW) begin : g_spare
      logic unused_pay;
      assign unused_pay = ^{tbl_word[PAY_W-1:0], seg_word[PAY_W-1:0]};
   end

   evmap_ram #(.AW(TBL_AW), .DW(WORD_W)) u_tbl (
      .clk   (clk),
      .we    (wr_en && !wr_seg),
      .waddr (wr_addr[TBL_AW-1:0]),
      .wdata (wr_data),
      .raddr (tbl_idx),
      .rdata (tbl_word)
   );

   evmap_ram #(.AW(SEG_AW), .DW(WORD_W)) u_seg (
      .clk   (clk),
      .we    (wr_en && wr_seg),
      .waddr (wr_addr[SEG_AW-1:0]),
      .wdata (wr_data),
      .raddr (seg_raddr),
      .rdata (seg_word)
   );

   evmap_ctrl #(.WORD_W(WORD_W), .OUT_W(OUT_W), .SEG_AW(SEG_AW)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_req    (in_req),
      .in_ack    (in_ack),
      .tbl_word  (tbl_word),
      .seg_word  (seg_word),
      .seg_raddr (seg_raddr),
      .out_req   (out_req),
      .out_addr  (out_addr),
      .out_ack   (out_ack),
      .err_flag  (err_flag)
   );
endmodule

// File: tb/sim_evmap_top.sv
module sim_evmap_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_req = 1'b0;
   logic [15:0] in_label = '0;
   logic        in_ack;
   logic        out_req;
   logic [15:0] out_addr;
   logic        out_ack = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_seg = 1'b0;
   logic [9:0]  wr_addr = '0;
   logic [23:0] wr_data = '0;
   logic        err_flag;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;

   logic [23:0] tm [1024];
   logic [23:0] sm [1024];
   logic [15:0] q [$];
   bit          exp_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   evmap_top u0 (
      .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_label(in_label),
      .in_ack(in_ack), .out_req(out_req), .out_addr(out_addr),
      .out_ack(out_ack), .wr_en(wr_en), .wr_seg(wr_seg),
      .wr_addr(wr_addr), .wr_data(wr_data), .err_flag(err_flag)
   );

   task automatic check(input bit ok, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   // R5: every cycle, ports never request and acknowledge at once
   always @(negedge clk)
      if (rst_n && !finished)
         check(!(out_req && in_ack), "R5 out_req with in_ack",
               {out_req, in_ack}, 2'b00);

   task automatic wr(input bit seg, input int a, input logic [23:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_seg = seg; wr_addr = a[9:0]; wr_data = d;
      if (seg) sm[a] = d; else tm[a] = d;
   endtask

   task automatic wr_end();
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // behavioural expectation of the fan-out for a label
   task automatic model(input logic [15:0] lbl);
      logic [23:0] w, s;
      int p;
      w = tm[lbl[9:0]];
      case (w[23:22])
         2'b11: q.push_back(w[15:0]);
         2'b01: begin
            p = int'(w[9:0]);
            for (int k = 0; k < 1024; k++) begin
               s = sm[p];
               if (s[23:22] == 2'b11) begin
                  q.push_back(s[15:0]);
                  p = (p + 1) % 1024;
               end else if (s[23:22] == 2'b10) begin
                  q.push_back(s[15:0]);
                  break;
               end else begin
                  exp_err = 1;
                  break;
               end
            end
         end
         default: ;
      endcase
   endtask

   task automatic send(input logic [15:0] lbl, input int lat_first,
                       input int ack_delay, input string tag);
      int  cyc;
      bit  first;
      bit  done;
      logic [15:0] e;
      logic [15:0] held;
      q.delete();
      model(lbl);
      @(negedge clk);
      in_req = 1'b1; in_label = lbl;
      cyc = 0; first = 1; done = 0;
      while (!done) begin
         @(negedge clk);
         cyc++;
         if (cyc > 100) begin
            check(0, {tag, " no response"}, cyc, lat_first);
            done = 1;
         end else if (out_req) begin
            if (first) check(cyc == lat_first, {tag, " first out_req latency"}, cyc, lat_first);
            else       check(cyc == 3, "R4 gap between targets", cyc, 3);
            first = 0;
            if (q.size() == 0) begin
               check(0, {tag, " unexpected output event"}, out_addr, 0);
            end else begin
               e = q.pop_front();
               check(out_addr == e, {tag, " out_addr"}, out_addr, e);
            end
            held = out_addr;
            for (int d = 0; d < ack_delay; d++) begin
               @(negedge clk);
               check(out_req && out_addr == held, "R6 request held until ack",
                     {out_req, out_addr}, {1'b1, held});
            end
            out_ack = 1'b1;
            @(negedge clk);
            check(!out_req, "R6 out_req released after ack", out_req, 0);
            out_ack = 1'b0;
            cyc = 0;
         end else if (in_ack) begin
            if (first) check(cyc == lat_first, {tag, " in_ack latency"}, cyc, lat_first);
            check(q.size() == 0, "R5 in_ack before fan-out complete", q.size(), 0);
            check(err_flag == exp_err, "R7 err_flag", err_flag, exp_err);
            @(negedge clk);
            check(in_ack, "R6 in_ack held while in_req high", in_ack, 1);
            in_req = 1'b0;
            @(negedge clk);
            check(!in_ack, "R6 in_ack released", in_ack, 0);
            done = 1;
         end
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired actual=hung expected=done");
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!out_req && !in_ack && !err_flag, "R1 reset state",
            {out_req, in_ack, err_flag}, 3'b000);

      // R9: load both stores through the write port
      for (int i = 0; i < 1024; i++) wr(0, i, 24'h0);
      for (int i = 0; i < 1024; i++) wr(1, i, 24'h0);
      wr(0, 5,  {2'b11, 6'd0, 16'hABCD});
      wr(0, 7,  {2'b01, 12'd0, 10'd100});
      wr(0, 8,  {2'b10, 6'd0, 16'h5555});
      wr(0, 9,  {2'b01, 12'd0, 10'd200});
      wr(0, 10, {2'b01, 12'd0, 10'd300});
      wr(1, 100, {2'b11, 6'd0, 16'h0101});
      wr(1, 101, {2'b11, 6'd0, 16'h0202});
      wr(1, 102, {2'b10, 6'd0, 16'h0303});
      wr(1, 200, {2'b11, 6'd0, 16'h0AAA});
      wr(1, 201, {2'b00, 6'd0, 16'h0BBB});
      wr(1, 300, {2'b10, 6'd0, 16'h0777});
      wr_end();

      send(16'd5,     2, 0, "R3 direct");
      send(16'd6,     2, 0, "R2 null");
      send(16'd7,     4, 2, "R4 walk");
      send(16'd10,    4, 0, "R4 single tail");
      send(16'd8,     2, 0, "R8 tail in table");
      check(!err_flag, "R8 no error from table tail", err_flag, 0);
      send(16'hFC05,  2, 1, "R10 high label bits");
      send(16'd9,     4, 0, "R7 corrupt segment");
      send(16'd5,     2, 0, "R7 sticky after error");
      check(err_flag, "R7 err_flag sticky", err_flag, 1);

      // R9: rewrites take effect for later events
      wr(0, 5,  {2'b11, 6'd0, 16'h1234});
      wr(1, 101, {2'b11, 6'd0, 16'h0999});
      wr_end();
      send(16'd5,     2, 0, "R9 rewritten direct");
      send(16'd7,     4, 0, "R9 rewritten segment");

      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule